// File: doc/BRIEF.md
# Serial Audio Codec Link Controller

This block is the controller end of a five-wire serial link to an audio codec. The codec supplies the bit clock. The controller drives the frame sync, the outgoing serial data line and the active-low codec reset, and it receives the incoming serial data line. Each frame is 256 bit clocks long in both directions. It is split into one 16-bit tag slot followed by twelve 20-bit data slots. Bits go out most significant first.

The block lives in the system clock domain. It oversamples the codec bit clock through a synchronizer and acts on the rising and falling transitions it detects. Outgoing data and sync are launched on detected rising transitions. Incoming data is captured on detected falling transitions.

After system reset the block holds the codec in reset for a fixed number of system clocks. Framing starts at the first bit-clock rise after the codec reset is released. The outgoing frames carry only zeros until a received tag slot reports the codec ready. Software-side logic sees all thirteen slots as parallel words:

- The outgoing words are sampled once per frame.
- The incoming words are refreshed with a one-cycle strobe when each frame has been fully received.

Top module: `aclink_ctrl`

## Requirements
- R1: After rst_ni is released, codec_rst_no stays low for exactly RST_CYCLES rising edges of clk_i. It then goes high and remains high until the next rst_ni assertion.
- R2: sync_o stays low while codec_rst_no is low. The first frame begins on the first bit-clock rise detected after codec_rst_no has gone high.
- R3: Every frame spans 256 bit clocks. sync_o is high for the first 16 bit clocks of each frame and low for the remaining 240.
- R4: Outgoing frame order is as follows. First come the 16 bits tx_slots_i[15:0] (slot 0). Then come slots 1 to 12, where slot k is tx_slots_i[20k+19:20k]. Each slot is sent most significant bit first, and each bit is launched after a bit-clock rise.
- R5: Incoming bits are sampled after each bit-clock fall and unpacked with the same layout into rx_slots_o. The upper four bits of the slot-0 field, rx_slots_o[19:16], read zero.
- R6: frame_done_o pulses high for exactly one clk_i cycle after the last bit of each frame is captured. rx_slots_o changes only in that same cycle.
- R7: link_up_o goes high at the end of the first received frame whose slot-0 bit 15 is 1. It then stays high regardless of later frames until rst_ni.
- R8: While link_up_o is low, every outgoing frame is all zeros, whatever the value of tx_slots_i.
- R9: tx_slots_i is sampled at each frame boundary. A change made in the middle of a frame first appears in the following frame.
- R10: rx_tag_valid_o[k-1] equals bit (15-k) of the slot-0 word of the last captured frame, for k = 1 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| bclk_i | input | 1 | Bit clock from the codec |
| sdata_in_i | input | 1 | Serial data from the codec |
| sync_o | output | 1 | Frame sync to the codec |
| sdata_out_o | output | 1 | Serial data to the codec |
| codec_rst_no | output | 1 | Active-low reset to the codec |
| tx_slots_i | input | 260 | Outgoing slots, slot k at [20k+19:20k], slot 0 uses [15:0] |
| rx_slots_o | output | 260 | Incoming slots, same layout |
| rx_tag_valid_o | output | 12 | Per-slot valid tags from the received tag slot |
| frame_done_o | output | 1 | One-cycle strobe per received frame |
| link_up_o | output | 1 | Codec has reported ready |

## Verification
The bench bit clock runs during the codec reset, which shows that sync stays quiet and that framing begins only after release. Five received frames are used:

- The first lacks the ready flag, which separates the zero-output phase from the active phase.
- The next two carry it with different tags, which separates sticky ready from per-frame copying of the tag field.
- The last two drop it again, which shows that link_up does not fall.

The outgoing slot words are changed in the middle of a frame. This distinguishes latching at the boundary from live serialization. Distinct per-slot values expose any misplaced slot boundary or reversed bit order.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  parameter int TAG_W_DEF     = 16;
  parameter int SLOT_W_DEF    = 20;
  parameter int NUM_SLOTS_DEF = 13;

  // frame position of the first (most significant) bit of slot k
  function automatic int slot_msb(int k, int fb, int tw, int sw);
    return (k == 0) ? fb - 1 : fb - 1 - tw - (k - 1) * sw;
  endfunction
endpackage

// File: rtl/aclink_bclk_edge.sv
module aclink_bclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[1:0], bclk_i};
  end

  assign rise_o = q[1] & ~q[2];
  assign fall_o = ~q[1] & q[2];
endmodule

// File: rtl/aclink_rst_seq.sv
module aclink_rst_seq #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic codec_rst_no
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt          <= '0;
      codec_rst_no <= 1'b0;
    end else if (!codec_rst_no) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(RST_CYCLES - 1)) codec_rst_no <= 1'b1;
    end
  end

  // R1
  rel_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_rst_no |=> codec_rst_no);

  // R1
  rel_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(codec_rst_no) |-> cnt == CW'(RST_CYCLES));
endmodule

// File: rtl/aclink_framer.sv
module aclink_framer #(
  parameter int TAG_W     = aclink_pkg::TAG_W_DEF,
  parameter int SLOT_W    = aclink_pkg::SLOT_W_DEF,
  parameter int NUM_SLOTS = aclink_pkg::NUM_SLOTS_DEF,
  localparam int FB       = TAG_W + (NUM_SLOTS - 1) * SLOT_W,
  localparam int FLAT_W   = NUM_SLOTS * SLOT_W,
  localparam int CNT_W    = $clog2(FB)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 sdata_i,
  input  logic [FLAT_W-1:0]    tx_slots_i,
  output logic                 sync_o,
  output logic                 sdata_o,
  output logic [FLAT_W-1:0]    rx_slots_o,
  output logic [NUM_SLOTS-2:0] tag_valid_o,
  output logic                 frame_done_o,
  output logic                 link_up_o
);
  logic [FB-1:0]     tx_vec, tx_sh, rx_vec;
  logic [FB-2:0]     rx_sh;
  logic [FLAT_W-1:0] rx_flat, rx_q;
  logic [CNT_W-1:0]  cnt;
  logic              run, last;
  logic              unused_hi;

  assign unused_hi = ^tx_slots_i[SLOT_W-1:TAG_W];
  assign rx_vec    = {rx_sh, sdata_i};
  assign last      = (cnt == CNT_W'(FB - 1));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int MSB = aclink_pkg::slot_msb(k, FB, TAG_W, SLOT_W);
    if (k == 0) begin : g_tag
      assign tx_vec[MSB -: TAG_W]    = tx_slots_i[TAG_W-1:0];
      assign rx_flat[SLOT_W-1:0]     = {{(SLOT_W-TAG_W){1'b0}}, rx_vec[MSB -: TAG_W]};
    end else begin : g_data
      assign tx_vec[MSB -: SLOT_W]            = tx_slots_i[k*SLOT_W +: SLOT_W];
      assign rx_flat[k*SLOT_W +: SLOT_W]      = rx_vec[MSB -: SLOT_W];
      assign tag_valid_o[k-1]                 = rx_q[TAG_W-1-k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run          <= 1'b0;
      cnt          <= '0;
      sync_o       <= 1'b0;
      sdata_o      <= 1'b0;
      tx_sh        <= '0;
      rx_sh        <= '0;
      rx_q         <= '0;
      frame_done_o <= 1'b0;
      link_up_o    <= 1'b0;
    end else begin
      frame_done_o <= 1'b0;
      if (rise_i && en_i) begin
        if (!run || last) begin
          // frame boundary: latch outgoing slots
          run     <= 1'b1;
          cnt     <= '0;
          sync_o  <= 1'b1;
          sdata_o <= link_up_o & tx_vec[FB-1];
          tx_sh   <= link_up_o ? {tx_vec[FB-2:0], 1'b0} : '0;
        end else begin
          cnt     <= cnt + 1'b1;
          sync_o  <= (cnt < CNT_W'(TAG_W - 1));
          sdata_o <= tx_sh[FB-1];
          tx_sh   <= {tx_sh[FB-2:0], 1'b0};
        end
      end
      if (fall_i && run) begin
        rx_sh <= rx_vec[FB-2:0];
        if (last) begin
          rx_q         <= rx_flat;
          frame_done_o <= 1'b1;
          if (rx_vec[FB-1]) link_up_o <= 1'b1;
        end
      end
    end
  end

  assign rx_slots_o = rx_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R7
  link_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |=> link_up_o);

  // R8
  quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_o |-> !sdata_o);

  // R2
  sync_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sync_o);

  // R3
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> cnt == '0);

  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_o |-> $stable(rx_slots_o));
endmodule

// File: rtl/aclink_ctrl.sv
module aclink_ctrl #(
  parameter int RST_CYCLES = 64,
  parameter int TAG_W      = aclink_pkg::TAG_W_DEF,
  parameter int SLOT_W     = aclink_pkg::SLOT_W_DEF,
  parameter int NUM_SLOTS  = aclink_pkg::NUM_SLOTS_DEF,
  localparam int FLAT_W    = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bclk_i,
  input  logic                 sdata_in_i,
  output logic                 sync_o,
  output logic                 sdata_out_o,
  output logic                 codec_rst_no,
  input  logic [FLAT_W-1:0]    tx_slots_i,
  output logic [FLAT_W-1:0]    rx_slots_o,
  output logic [NUM_SLOTS-2:0] rx_tag_valid_o,
  output logic                 frame_done_o,
  output logic                 link_up_o
);
  logic rise, fall;

  aclink_bclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (bclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  aclink_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .codec_rst_no (codec_rst_no)
  );

  aclink_framer #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (codec_rst_no),
    .rise_i       (rise),
    .fall_i       (fall),
    .sdata_i      (sdata_in_i),
    .tx_slots_i   (tx_slots_i),
    .sync_o       (sync_o),
    .sdata_o      (sdata_out_o),
    .rx_slots_o   (rx_slots_o),
    .tag_valid_o  (rx_tag_valid_o),
    .frame_done_o (frame_done_o),
    .link_up_o    (link_up_o)
  );
endmodule

// File: tb/aclink_ctrl_bench.sv
module aclink_ctrl_bench;
  localparam int RST  = 64;
  localparam int NS   = 13;
  localparam int SW   = 20;
  localparam int TW   = 16;
  localparam int FB   = 256;
  localparam int FW   = NS * SW;
  localparam int HALF = 5;
  localparam int NFR  = 5;

  logic clk = 1'b0, rst_ni = 1'b0, bclk = 1'b0, sdin = 1'b0;
  logic [FW-1:0] tx_slots = '0;
  logic sync_o, sdata_out_o, codec_rst_no, frame_done_o, link_up_o;
  logic [FW-1:0] rx_slots_o;
  logic [NS-2:0] rx_tag_valid_o;

  aclink_ctrl #(.RST_CYCLES(RST)) u_aclink_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .sdata_in_i(sdin),
    .sync_o(sync_o), .sdata_out_o(sdata_out_o), .codec_rst_no(codec_rst_no),
    .tx_slots_i(tx_slots), .rx_slots_o(rx_slots_o), .rx_tag_valid_o(rx_tag_valid_o),
    .frame_done_o(frame_done_o), .link_up_o(link_up_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] to_frame(logic [FW-1:0] f);
    logic [FB-1:0] v = '0;
    int p = FB - 1;
    for (int b = TW - 1; b >= 0; b--) begin v[p] = f[b]; p--; end
    for (int s = 1; s < NS; s++)
      for (int b = SW - 1; b >= 0; b--) begin v[p] = f[s*SW + b]; p--; end
    return v;
  endfunction

  function automatic logic [FW-1:0] mk(int seed, bit rdy);
    logic [FW-1:0] f = '0;
    for (int s = 1; s < NS; s++) f[s*SW +: SW] = SW'((seed * 131071 + s * 40503) ^ (s << (seed % 7)));
    f[TW-2:3] = 12'(seed * 291 + 17);
    f[TW-1]   = rdy;
    return f;
  endfunction

  // scoreboard queues
  logic [FB-1:0] out_q[$];
  string         out_r[$];
  logic [FW-1:0] rx_q[$];
  bit ready_seen = 0;
  int done_cnt = 0;

  // monitor for received frames
  always @(negedge clk) begin : mon
    logic [FW-1:0] e;
    logic [NS-2:0] tg;
    if (rst_ni && frame_done_o) begin
      done_cnt++;
      if (rx_q.size() == 0) chk(1'b0, "R6 unexpected frame_done", '0, '0);
      else begin
        e = rx_q.pop_front();
        chk(rx_slots_o == e, "R5 rx slots", rx_slots_o, e);
        for (int k = 1; k < NS; k++) tg[k-1] = e[TW-1-k];
        chk(rx_tag_valid_o == tg, "R10 tag valid", FW'(rx_tag_valid_o), FW'(tg));
        if (e[TW-1]) ready_seen = 1;
        chk(link_up_o == ready_seen, "R7 link_up", FW'(link_up_o), FW'(ready_seen));
      end
    end
  end

  // R1 codec reset duration
  initial begin
    int n;
    @(posedge rst_ni);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (codec_rst_no) break;
    end
    chk(n == RST, "R1 codec reset length", FW'(n), FW'(RST));
    repeat (30) @(negedge clk);
    chk(codec_rst_no == 1'b1, "R1 codec reset stays released", FW'(codec_rst_no), FW'(1));
  end

  logic [FW-1:0] cf[NFR];
  logic [FW-1:0] t1, t2;
  logic [FB-1:0] cur_in, out_cap;
  bit aligned = 0, first_chk = 0, pre_bad = 0, rel_rise;
  int pos = 0, fidx = 0, sync_bad = 0, frames_seen = 0;

  task automatic start_frame();
    fidx++;
    if (fidx <= NFR) begin
      cur_in = to_frame(cf[fidx-1]);
      rx_q.push_back(cf[fidx-1]);
      if (fidx <= 2) begin out_q.push_back('0);            out_r.push_back("R8 zero frame before ready"); end
      else if (fidx == 3) begin out_q.push_back(to_frame(t1)); out_r.push_back("R4 out frame order"); end
      else begin out_q.push_back(to_frame(t2)); out_r.push_back("R9 boundary latch"); end
    end else cur_in = '0;
  endtask

  task automatic end_frame();
    logic [FB-1:0] e;
    string r;
    e = out_q.pop_front();
    r = out_r.pop_front();
    chk(out_cap == e, r, FW'(out_cap), FW'(e));
    chk(sync_bad == 0, "R3 sync width", FW'(sync_bad), '0);
    sync_bad = 0;
    frames_seen++;
  endtask

  initial begin
    bit s, d;
    for (int i = 0; i < NFR; i++) cf[i] = mk(i + 3, (i == 1 || i == 2));
    t1 = mk(11, 1'b1);
    t2 = mk(23, 1'b0);
    tx_slots = t1;
    repeat (3) @(negedge clk);
    chk(codec_rst_no == 1'b0, "R1 reset state codec_rst_no", FW'(codec_rst_no), '0);
    chk(sync_o == 1'b0, "R2 reset state sync", FW'(sync_o), '0);
    chk(sdata_out_o == 1'b0, "R8 reset state sdata_out", FW'(sdata_out_o), '0);
    chk(link_up_o == 1'b0, "R7 reset state link_up", FW'(link_up_o), '0);
    chk(frame_done_o == 1'b0, "R6 reset state frame_done", FW'(frame_done_o), '0);
    @(negedge clk) rst_ni = 1'b1;

    while (frames_seen < NFR) begin
      // rising half: codec launches next bit
      bclk = 1'b1;
      rel_rise = codec_rst_no;
      if (aligned) begin
        if ((pos + 1) % FB == 0) start_frame();
        sdin = cur_in[FB-1-((pos + 1) % FB)];
      end
      repeat (HALF) @(negedge clk);
      s = sync_o;
      d = sdata_out_o;
      if (!aligned) begin
        if (!rel_rise && s) pre_bad = 1;
        if (rel_rise && !first_chk) begin
          first_chk = 1;
          chk(s == 1'b1, "R2 framing starts at first rise", FW'(s), FW'(1));
        end
        if (s) begin
          aligned = 1;
          pos = 0;
          chk(!pre_bad, "R2 no sync during codec reset", FW'(pre_bad), '0);
          start_frame();
        end
      end else pos = (pos + 1) % FB;
      if (aligned) begin
        if (s != (pos < TW)) sync_bad++;
        out_cap[FB-1-pos] = d;
        if (pos == FB - 1) end_frame();
        if (fidx == 3 && pos == 100) tx_slots = t2;
      end
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == NFR, "R6 one strobe per frame", FW'(done_cnt), FW'(NFR));
    chk(link_up_o == 1'b1, "R7 link_up sticky", FW'(link_up_o), FW'(1));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R6 frames=%0d", frames_seen);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule